// File: doc/BRIEF.md
# Open-Row-First Per-Bank Request Selector

This block keeps the memory requests that wait for service, one age-ordered queue for each bank. A request enters with a bank index, a row address and a tag. The tag is the handle by which the request is later taken out again. The removal can hit any position in the queue, and the entries that remain keep their age order.

A bank controller asks for work by presenting a query: a bank index, a flag that says whether that bank currently has a row open, and the open row address. The block answers in the same cycle with the tag to serve next. It prefers the oldest waiting request that targets the open row. When nothing targets that row, or when the bank has no open row, it answers with the oldest request of the bank.

Two hint flags come with the answer:
- One says the bank holds at least one more request besides the one selected.
- One says at least two queued requests target the queried row, so the row is worth keeping open.

An enqueue into a full bank queue is refused and flagged.

Top module: `frfcfs_bank_selector`

## Requirements
- R1: An accepted enqueue appends its request behind all requests already queued for the same bank. With no row preference (`qry_active` low) the bank's requests are returned oldest first.
- R2: When the queried bank's queue is empty, `sel_valid` is 0 and both hint flags are 0.
- R3: When `qry_active` is 1, `sel_tag` is the tag of the oldest queued request of the queried bank whose row equals `qry_open_row`.
- R4: When `qry_active` is 0, or no queued request of the bank has row `qry_open_row`, `sel_tag` is the tag of the bank's oldest request.
- R5: A remove with a tag present in a queue deletes the oldest entry carrying that tag from that bank's queue, at any position. The remaining entries keep their relative order.
- R6: `further_req` is 1 exactly when the queried bank holds two or more requests.
- R7: `further_hit` is 1 exactly when two or more requests of the queried bank have row `qry_open_row`. This holds whatever the value of `qry_active`.
- R8: An enqueue to a bank whose queue already holds DEPTH entries changes nothing. `enq_error` is 1 in the following cycle, and is 0 after every other cycle.
- R9: A remove whose tag matches no queued entry leaves all queues unchanged.
- R10: All selection outputs are combinational from the queue registers. A request enqueued or removed at one clock edge is reflected in query answers from that edge on.
- R11: When an enqueue and a remove arrive in the same cycle, the removal is applied first and the new request then goes to the tail. Whether the queue is full is judged on its occupancy before the removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, empties all queues |
| enq_valid | input | 1 | Enqueue request this cycle |
| enq_bank | input | BANK_W | Bank of the new request |
| enq_row | input | ROW_W | Row of the new request |
| enq_tag | input | TAG_W | Tag of the new request |
| enq_error | output | 1 | Previous cycle's enqueue was refused because the queue was full |
| rem_valid | input | 1 | Remove request this cycle |
| rem_tag | input | TAG_W | Tag to remove |
| qry_bank | input | BANK_W | Bank being queried |
| qry_active | input | 1 | Queried bank has a row open |
| qry_open_row | input | ROW_W | Open row of the queried bank, also the row counted for `further_hit` |
| sel_valid | output | 1 | A request is selected |
| sel_tag | output | TAG_W | Tag of the selected request |
| further_hit | output | 1 | Two or more queued requests target `qry_open_row` |
| further_req | output | 1 | Two or more requests are queued for the bank |

## Verification
The four selection outputs are due in the same cycle as the query. They describe the queues as left by the last clock edge. The bench therefore drives every input just after a falling edge and samples the answers one time unit later. At that point the reference model still holds the pre-edge contents. `enq_error` is due one edge after the refused enqueue. The bench keeps the expected value from the previous cycle and compares it at the next falling edge, before it advances the model for the stimulus just driven.

// File: rtl/frq_pkg.sv
package frq_pkg;
  // Width of a counter that must hold values 0..n inclusive.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/frq_bank_queue.sv
module frq_bank_queue
  import frq_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int ROW_W   = 8,
  parameter int TAG_W   = 6,
  parameter int BANK_W  = 2,
  parameter int BANK_ID = 0,
  localparam int CNT_W  = cnt_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_valid,
  input  logic [BANK_W-1:0] enq_bank,
  input  logic [ROW_W-1:0]  enq_row,
  input  logic [TAG_W-1:0]  enq_tag,
  input  logic              rem_valid,
  input  logic [TAG_W-1:0]  rem_tag,
  output logic [ROW_W-1:0]  q_rows [DEPTH],
  output logic [TAG_W-1:0]  q_tags [DEPTH],
  output logic [CNT_W-1:0]  q_cnt,
  output logic              q_full
);
  logic [DEPTH-1:0] tag_hit;
  logic [CNT_W-1:0] first_idx;
  logic             rem_hit;
  logic             push;
  logic [CNT_W-1:0] cnt_after;

  assign q_full = (q_cnt == CNT_W'(DEPTH));

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      tag_hit[i] = rem_valid && (CNT_W'(i) < q_cnt) && (q_tags[i] == rem_tag);
  end

  // Oldest matching slot wins: scan from the tail down to the head.
  always_comb begin
    first_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (tag_hit[i]) first_idx = CNT_W'(i);
  end

  assign rem_hit   = |tag_hit;
  assign push      = enq_valid && (enq_bank == BANK_W'(BANK_ID)) && !q_full;
  assign cnt_after = q_cnt - CNT_W'(rem_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cnt <= '0;
    end else begin
      // Close the gap left by the removed entry.
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (rem_hit && CNT_W'(i) >= first_idx) begin
          q_rows[i] <= q_rows[i+1];
          q_tags[i] <= q_tags[i+1];
        end
      end
      // Append after the removal has been applied.
      for (int i = 0; i < DEPTH; i++) begin
        if (push && cnt_after == CNT_W'(i)) begin
          q_rows[i] <= enq_row;
          q_tags[i] <= enq_tag;
        end
      end
      q_cnt <= cnt_after + CNT_W'(push);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    q_cnt <= CNT_W'(DEPTH));

  assert_miss_keeps_count_R9: assert property (@(posedge clk) disable iff (rst)
    (rem_valid && !rem_hit && !push) |=> $stable(q_cnt));

  assert_push_grows_R1: assert property (@(posedge clk) disable iff (rst)
    (push && !rem_hit) |=> (q_cnt == $past(q_cnt) + CNT_W'(1)));

  assert_full_refused_R11: assert property (@(posedge clk) disable iff (rst)
    (q_full && !rem_hit) |=> (q_cnt == CNT_W'(DEPTH)));
endmodule

// File: rtl/frq_pick.sv
module frq_pick
  import frq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ROW_W  = 8,
  parameter int TAG_W  = 6,
  localparam int CNT_W = cnt_width(DEPTH)
) (
  input  logic [ROW_W-1:0] rows [DEPTH],
  input  logic [TAG_W-1:0] tags [DEPTH],
  input  logic [CNT_W-1:0] cnt,
  input  logic             active,
  input  logic [ROW_W-1:0] open_row,
  output logic             sel_valid,
  output logic [TAG_W-1:0] sel_tag,
  output logic             further_hit,
  output logic             further_req
);
  logic [DEPTH-1:0] row_match;
  logic [TAG_W-1:0] hit_tag;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      row_match[i] = (CNT_W'(i) < cnt) && (rows[i] == open_row);
  end

  // Oldest entry on the open row.
  always_comb begin
    hit_tag = tags[0];
    for (int i = DEPTH - 1; i >= 0; i--)
      if (row_match[i]) hit_tag = tags[i];
  end

  assign sel_valid   = (cnt != '0);
  assign sel_tag     = (active && |row_match) ? hit_tag : tags[0];
  assign further_req = (cnt >= CNT_W'(2));
  assign further_hit = ($countones(row_match) >= 2);
endmodule

// File: rtl/frfcfs_bank_selector.sv
module frfcfs_bank_selector
  import frq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 4,
  parameter int ROW_W     = 8,
  parameter int TAG_W     = 6,
  localparam int BANK_W   = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS),
  localparam int CNT_W    = cnt_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_valid,
  input  logic [BANK_W-1:0] enq_bank,
  input  logic [ROW_W-1:0]  enq_row,
  input  logic [TAG_W-1:0]  enq_tag,
  output logic              enq_error,
  input  logic              rem_valid,
  input  logic [TAG_W-1:0]  rem_tag,
  input  logic [BANK_W-1:0] qry_bank,
  input  logic              qry_active,
  input  logic [ROW_W-1:0]  qry_open_row,
  output logic              sel_valid,
  output logic [TAG_W-1:0]  sel_tag,
  output logic              further_hit,
  output logic              further_req
);
  logic [ROW_W-1:0]     all_rows [NUM_BANKS][DEPTH];
  logic [TAG_W-1:0]     all_tags [NUM_BANKS][DEPTH];
  logic [CNT_W-1:0]     all_cnt  [NUM_BANKS];
  logic [NUM_BANKS-1:0] all_full;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    frq_bank_queue #(
      .DEPTH(DEPTH), .ROW_W(ROW_W), .TAG_W(TAG_W),
      .BANK_W(BANK_W), .BANK_ID(g)
    ) i_queue (
      .clk(clk), .rst(rst),
      .enq_valid(enq_valid), .enq_bank(enq_bank),
      .enq_row(enq_row), .enq_tag(enq_tag),
      .rem_valid(rem_valid), .rem_tag(rem_tag),
      .q_rows(all_rows[g]), .q_tags(all_tags[g]),
      .q_cnt(all_cnt[g]), .q_full(all_full[g])
    );
  end

  frq_pick #(.DEPTH(DEPTH), .ROW_W(ROW_W), .TAG_W(TAG_W)) i_pick (
    .rows(all_rows[qry_bank]), .tags(all_tags[qry_bank]),
    .cnt(all_cnt[qry_bank]), .active(qry_active), .open_row(qry_open_row),
    .sel_valid(sel_valid), .sel_tag(sel_tag),
    .further_hit(further_hit), .further_req(further_req)
  );

  always_ff @(posedge clk) begin
    if (rst) enq_error <= 1'b0;
    else     enq_error <= enq_valid && all_full[enq_bank];
  end

  assert_full_flags_error_R8: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && all_full[enq_bank]) |=> enq_error);

  assert_empty_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (all_cnt[qry_bank] == '0) |-> (!sel_valid && !further_req && !further_hit));

  assert_more_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
    further_req |-> sel_valid);

  assert_hit_needs_more_R7: assert property (@(posedge clk) disable iff (rst)
    further_hit |-> further_req);
endmodule

// File: tb/test_frfcfs_bank_selector.sv
module test_frfcfs_bank_selector;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int D  = 4;
  localparam int RW = 8;
  localparam int TW = 6;

  logic          clk = 0;
  logic          rst = 1;
  logic          enq_valid = 0;
  logic [1:0]    enq_bank = 0;
  logic [RW-1:0] enq_row = 0;
  logic [TW-1:0] enq_tag = 0;
  logic          enq_error;
  logic          rem_valid = 0;
  logic [TW-1:0] rem_tag = 0;
  logic [1:0]    qry_bank = 0;
  logic          qry_active = 0;
  logic [RW-1:0] qry_open_row = 0;
  logic          sel_valid;
  logic [TW-1:0] sel_tag;
  logic          further_hit;
  logic          further_req;

  frfcfs_bank_selector #(.NUM_BANKS(NB), .DEPTH(D), .ROW_W(RW), .TAG_W(TW))
  i_frfcfs_bank_selector (
    .clk(clk), .rst(rst),
    .enq_valid(enq_valid), .enq_bank(enq_bank), .enq_row(enq_row),
    .enq_tag(enq_tag), .enq_error(enq_error),
    .rem_valid(rem_valid), .rem_tag(rem_tag),
    .qry_bank(qry_bank), .qry_active(qry_active), .qry_open_row(qry_open_row),
    .sel_valid(sel_valid), .sel_tag(sel_tag),
    .further_hit(further_hit), .further_req(further_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model
  int mrow [NB][D];
  int mtag [NB][D];
  int mcnt [NB];
  bit exp_err = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit tag_present(input int t);
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < mcnt[b]; i++)
        if (mtag[b][i] == t) return 1;
    return 0;
  endfunction

  function automatic int exp_pick(input int b, input bit act, input int r);
    if (act)
      for (int i = 0; i < mcnt[b]; i++)
        if (mrow[b][i] == r) return mtag[b][i];
    return mtag[b][0];
  endfunction

  function automatic bit has_open_hit(input int b, input int r);
    for (int i = 0; i < mcnt[b]; i++)
      if (mrow[b][i] == r) return 1;
    return 0;
  endfunction

  function automatic int exp_hits(input int b, input int r);
    int n = 0;
    for (int i = 0; i < mcnt[b]; i++)
      if (mrow[b][i] == r) n++;
    return n;
  endfunction

  // One cycle: drive after a falling edge, check the pre-edge state, advance the model.
  task automatic cycle(input bit ev, input int eb, input int er, input int et,
                       input bit rv, input int rt,
                       input int qb, input bit qa, input int qr);
    @(negedge clk);
    enq_valid = ev; enq_bank = 2'(eb); enq_row = RW'(er); enq_tag = TW'(et);
    rem_valid = rv; rem_tag = TW'(rt);
    qry_bank = 2'(qb); qry_active = qa; qry_open_row = RW'(qr);
    #1;
    check(enq_error == exp_err, "R8 enq_error", enq_error, exp_err);
    check(sel_valid == (mcnt[qb] != 0), "R2 sel_valid", sel_valid, mcnt[qb] != 0);
    if (mcnt[qb] != 0) begin
      if (qa && has_open_hit(qb, qr))
        check(sel_tag == TW'(exp_pick(qb, qa, qr)), "R3 sel_tag open-row hit",
              sel_tag, exp_pick(qb, qa, qr));
      else
        check(sel_tag == TW'(exp_pick(qb, qa, qr)), "R1/R4 sel_tag oldest",
              sel_tag, exp_pick(qb, qa, qr));
    end
    check(further_req == (mcnt[qb] >= 2), "R6 further_req", further_req, mcnt[qb] >= 2);
    check(further_hit == (exp_hits(qb, qr) >= 2), "R7 further_hit",
          further_hit, exp_hits(qb, qr) >= 2);
    // Model update (R11: fullness judged before the removal, removal before append).
    exp_err = ev && (mcnt[eb] == D);
    begin
      bit full_before = (mcnt[eb] == D);
      if (rv)
        for (int b = 0; b < NB; b++) begin
          int idx = -1;
          for (int i = mcnt[b] - 1; i >= 0; i--)
            if (mtag[b][i] == rt) idx = i;
          if (idx >= 0) begin
            for (int i = idx; i < mcnt[b] - 1; i++) begin
              mrow[b][i] = mrow[b][i+1];
              mtag[b][i] = mtag[b][i+1];
            end
            mcnt[b]--;
          end
        end
      if (ev && !full_before) begin
        mrow[eb][mcnt[eb]] = er;
        mtag[eb][mcnt[eb]] = et;
        mcnt[eb]++;
      end
    end
  endtask

  task automatic idle_query(input int qb, input bit qa, input int qr);
    cycle(0, 0, 0, 0, 0, 0, qb, qa, qr);
  endtask

  int unsigned seed = 32'd1234;

  function automatic int fresh_tag();
    int t;
    do t = int'($urandom() % 64); while (tag_present(t));
    return t;
  endfunction

  initial begin
    for (int b = 0; b < NB; b++) mcnt[b] = 0;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    #1;
    check(sel_valid == 0 && further_req == 0 && further_hit == 0 && enq_error == 0,
          "R2 reset idle", {sel_valid, further_req, further_hit, enq_error}, 0);
    @(negedge clk);
    rst = 0;

    // Directed: bank 1 gets rows 5,7,5,9 with tags 10..13.
    cycle(1, 1, 5, 10, 0, 0, 1, 0, 0);
    idle_query(1, 0, 0);
    check(sel_valid == 1 && sel_tag == 10, "R10 enqueue visible next cycle", sel_tag, 10);
    cycle(1, 1, 7, 11, 0, 0, 1, 1, 7);
    cycle(1, 1, 5, 12, 0, 0, 1, 1, 7);
    cycle(1, 1, 9, 13, 0, 0, 1, 1, 9);
    idle_query(1, 1, 5);
    check(sel_tag == 10 && further_hit == 1, "R3/R7 oldest hit on row 5", sel_tag, 10);
    idle_query(1, 1, 9);
    check(sel_tag == 13 && further_hit == 0, "R3 single hit on row 9", sel_tag, 13);
    idle_query(1, 1, 3);
    check(sel_tag == 10, "R4 no hit falls back to oldest", sel_tag, 10);
    idle_query(1, 0, 9);
    check(sel_tag == 10, "R4 precharged returns oldest", sel_tag, 10);
    // Overflow.
    cycle(1, 1, 9, 14, 0, 0, 1, 0, 0);
    idle_query(1, 0, 0);
    check(enq_error == 1, "R8 full refused flagged", enq_error, 1);
    idle_query(1, 1, 9);
    check(sel_tag == 13 && further_hit == 0, "R8 refused entry absent", sel_tag, 13);
    // Unknown tag removal.
    cycle(0, 0, 0, 0, 1, 50, 1, 0, 0);
    idle_query(1, 1, 9);
    check(further_req == 1 && sel_tag == 13, "R9 unknown remove no change", sel_tag, 13);
    // Remove from the middle: tag 11 (row 7); order 10,12,13 remains.
    cycle(0, 0, 0, 0, 1, 11, 1, 0, 0);
    idle_query(1, 1, 7);
    check(sel_tag == 10, "R5 removed entry gone", sel_tag, 10);
    cycle(0, 0, 0, 0, 1, 10, 1, 0, 0);
    idle_query(1, 1, 7);
    check(sel_tag == 12, "R5 order kept after removal", sel_tag, 12);
    // Fill to full again, then enqueue with simultaneous remove: refused (R11).
    cycle(1, 1, 2, 20, 0, 0, 1, 0, 0);
    cycle(1, 1, 2, 21, 0, 0, 1, 0, 0);
    cycle(1, 1, 4, 22, 1, 12, 1, 0, 0);
    idle_query(1, 1, 4);
    check(enq_error == 1 && further_hit == 0, "R11 full judged before removal", enq_error, 1);
    // Not full now: remove and enqueue same cycle, new entry goes to tail.
    cycle(1, 1, 4, 23, 1, 13, 1, 0, 0);
    idle_query(1, 0, 4);
    check(sel_tag == 20 && enq_error == 0, "R11 remove then append", sel_tag, 20);
    idle_query(2, 1, 4);
    check(sel_valid == 0, "R2 other bank empty", sel_valid, 0);

    // Random phase.
    for (int n = 0; n < 4000; n++) begin
      bit ev = ($urandom() % 3) != 0;
      int eb = int'($urandom() % NB);
      int er = int'($urandom() % 4);
      int et = fresh_tag();
      bit rv = ($urandom() % 3) == 0;
      int rt = int'($urandom() % 64);
      int qb = int'($urandom() % NB);
      if (rv && ($urandom() % 4) != 0) begin
        int rb = int'($urandom() % NB);
        if (mcnt[rb] > 0) rt = mtag[rb][int'($urandom() % mcnt[rb])];
      end
      cycle(ev, eb, er, et, rv, rt, qb, ($urandom() % 2) == 1, int'($urandom() % 4));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule